// File: doc/BRIEF.md
# Block Transfer Sequencer Between Host Port and Memory Port

This block copies a fixed-length image between a host processor and a memory, one 64-bit block at a time. On the host side it is a memory-mapped slave. On the memory side it is a memory-mapped master. A one-cycle start pulse, qualified by a mode input, begins an operation. The block then walks a fixed number of blocks upward from a base byte address.

In load mode, each step waits for the host to write one block, then writes that block to memory. In unload mode, each step reads one block from memory, then offers it to one host read. The host decides when its accesses happen. The block paces the host only through its waitrequest output, which stays high except while the block is ready for the host. On the memory side, an access may finish at once or be held off by the memory's waitrequest for any number of cycles. Read data may arrive in the same cycle the read is accepted or any number of cycles later.

A block is four 16-bit words. The base address and the step count are parameters: the defaults are the start of the top megabyte of a 1 GiB region and 130,326 steps. A busy output covers the operation, and a one-cycle done pulse ends it.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy_o and done_o are 0, h_waitrequest_o is 1, and m_write_o and m_read_o are 0.
- R2: Mode encoding: mode_i = 0 selects load and mode_i = 1 selects unload.
  - A start_i pulse is acted on only when the block is idle. busy_o rises in the cycle after the edge that samples start_i.
  - A start_i pulse while an operation runs has no effect on any output.
- R3: h_waitrequest_o is 1 except in the host window. The window is the phase that waits for a host write in load mode, or the phase that holds a ready block for a host read in unload mode.
  - A host request is accepted at the edge where it is high and h_waitrequest_o is 0.
  - This holds whether the request was raised before the window, on its first cycle, or later.
- R4: In load mode, m_write_o is 1 from the cycle after the host write is accepted. It carries the captured block with m_byteenable_o all ones.
  - m_write_o, m_address_o and m_writedata_o stay unchanged until an edge where m_waitrequest_i is 0.
- R5: Step k (counting from 0) uses memory byte address BASE_ADDR + 8*k. A block is 8 bytes.
- R6: In unload mode, m_read_o stays 1 with a steady address until an edge where m_waitrequest_i is 0.
  - The block is captured at the edge where m_readdatavalid_i is 1. That edge may be the accepting edge itself or any later one.
  - The host window opens in the cycle after the capture.
- R7: During an unload host window, h_readdata_o equals the captured block and holds stable until the host read is accepted.
- R8: An operation completes exactly STEP_COUNT steps.
  - done_o is 1 for exactly one cycle: the cycle after the final step's acceptance edge. busy_o is 0 in that cycle.
  - busy_o is 1 in every other cycle from the first busy cycle to the done cycle.
- R9: m_write_o and m_read_o are never 1 in the same cycle.
- R10: A block holds four 16-bit words. Word i sits in bits 16i+15 down to 16i, and every word passes between the ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins an operation |
| mode_i | input | 1 | 0 = load, 1 = unload; sampled with start_i |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle pulse after the last step |
| h_write_i | input | 1 | Host write request |
| h_writedata_i | input | 64 | Host write block |
| h_read_i | input | 1 | Host read request |
| h_readdata_o | output | 64 | Block returned to the host |
| h_waitrequest_o | output | 1 | Stalls the host; low only in the host window |
| m_address_o | output | 32 | Memory byte address |
| m_write_o | output | 1 | Memory write request |
| m_writedata_o | output | 64 | Memory write block |
| m_byteenable_o | output | 8 | Byte enables, all ones |
| m_read_o | output | 1 | Memory read request |
| m_waitrequest_i | input | 1 | Memory stall |
| m_readdata_i | input | 64 | Memory read block |
| m_readdatavalid_i | input | 1 | Memory read data valid |

## Verification
The block's outputs are decoded from registered state, so each one is due in the cycle after the edge that samples its cause. Examples:
- busy_o rises after the start edge.
- m_write_o rises after the host write edge.
- The host window opens after the readdatavalid edge.
- done_o rises after the final acceptance edge.

The bench drives inputs on the falling edge and steps a behavioural reference model at that same point, using the values it has just driven. It compares every output with the model on the next falling edge, which is one full register stage later. Separate counters check each accepted memory write and host read against values derived from the step number. They also confirm that the number of completed steps equals STEP_COUNT.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_HOST_WR  = 3'd1,
      ST_MEM_WR   = 3'd2,
      ST_MEM_RD   = 3'd3,
      ST_MEM_RDV  = 3'd4,
      ST_HOST_RD  = 3'd5,
      ST_DONE     = 3'd6
   } xfer_state_e;

   typedef enum logic {
      MODE_LOAD   = 1'b0,
      MODE_UNLOAD = 1'b1
   } xfer_mode_e;

endpackage

// File: rtl/xfer_step_ctr.sv
module xfer_step_ctr #(
   parameter int                 ADDR_W      = 32,
   parameter int                 STEP_COUNT  = 130326,
   parameter int                 BLOCK_BYTES = 8,
   parameter logic [ADDR_W-1:0]  BASE_ADDR   = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);

   localparam int CNT_W = (STEP_COUNT > 1) ? $clog2(STEP_COUNT) : 1;
   localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(STEP_COUNT - 1);
   localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(BLOCK_BYTES);
   localparam longint SPAN_END = longint'(BASE_ADDR) + longint'(STEP_COUNT) * longint'(BLOCK_BYTES);

   if (STEP_COUNT < 1) begin : g_bad_count
      $error("xfer_step_ctr: STEP_COUNT must be at least 1");
   end
   if ((longint'(BASE_ADDR) % longint'(BLOCK_BYTES)) != 0) begin : g_bad_align
      $error("xfer_step_ctr: BASE_ADDR must be block aligned");
   end
   if (SPAN_END > (longint'(1) <<< ADDR_W)) begin : g_bad_span
      $error("xfer_step_ctr: transfer span exceeds the address space");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         addr_q <= BASE_ADDR;
      end else if (clear_i) begin
         cnt_q  <= '0;
         addr_q <= BASE_ADDR;
      end else if (adv_i) begin
         cnt_q  <= cnt_q + CNT_W'(1);
         addr_q <= addr_q + STRIDE;
      end
   end

   assign addr_o = addr_q;
   assign last_o = (cnt_q == LAST_IDX);

   // R8: step index never passes the final step
   p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST_IDX);

   // R5: each advance moves the address by exactly one block
   p_addr_stride_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clear_i) |=> (addr_q == $past(addr_q) + STRIDE));

endmodule

// File: rtl/xfer_blk_reg.sv
module xfer_blk_reg #(
   parameter int WORD_W     = 16,
   parameter int WORDS      = 4,
   parameter bit DATA_RESET = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      cap_a_i,
   input  logic [WORD_W*WORDS-1:0]   data_a_i,
   input  logic                      cap_b_i,
   input  logic [WORD_W*WORDS-1:0]   data_b_i,
   output logic [WORD_W*WORDS-1:0]   q_o
);

   if (WORD_W < 1 || WORDS < 1) begin : g_bad_shape
      $error("xfer_blk_reg: WORD_W and WORDS must be positive");
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_lane
      logic [WORD_W-1:0] word_q;

      if (DATA_RESET) begin : g_rst
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               word_q <= '0;
            end else if (cap_a_i) begin
               word_q <= data_a_i[w*WORD_W +: WORD_W];
            end else if (cap_b_i) begin
               word_q <= data_b_i[w*WORD_W +: WORD_W];
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk_i) begin
            if (cap_a_i) begin
               word_q <= data_a_i[w*WORD_W +: WORD_W];
            end else if (cap_b_i) begin
               word_q <= data_b_i[w*WORD_W +: WORD_W];
            end
         end
      end

      assign q_o[w*WORD_W +: WORD_W] = word_q;
   end

   // R10: a block is captured from one side only
   p_one_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cap_a_i && cap_b_i));

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
   import xfer_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic mode_i,
   input  logic h_write_i,
   input  logic h_read_i,
   input  logic m_wait_i,
   input  logic m_rdv_i,
   input  logic last_i,
   output logic h_wait_o,
   output logic m_write_o,
   output logic m_read_o,
   output logic cap_host_o,
   output logic cap_mem_o,
   output logic ctr_clear_o,
   output logic ctr_adv_o,
   output logic rd_win_o,
   output logic busy_o,
   output logic done_o
);

   xfer_state_e state_q, state_d;
   logic        step_end;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i)   state_d = (mode_i == MODE_UNLOAD) ? ST_MEM_RD : ST_HOST_WR;
         ST_HOST_WR: if (h_write_i) state_d = ST_MEM_WR;
         ST_MEM_WR:  if (!m_wait_i) state_d = last_i ? ST_DONE : ST_HOST_WR;
         ST_MEM_RD:  if (!m_wait_i) state_d = m_rdv_i ? ST_HOST_RD : ST_MEM_RDV;
         ST_MEM_RDV: if (m_rdv_i)   state_d = ST_HOST_RD;
         ST_HOST_RD: if (h_read_i)  state_d = last_i ? ST_DONE : ST_MEM_RD;
         ST_DONE:                   state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign h_wait_o    = !((state_q == ST_HOST_WR) || (state_q == ST_HOST_RD));
   assign m_write_o   = (state_q == ST_MEM_WR);
   assign m_read_o    = (state_q == ST_MEM_RD);
   assign rd_win_o    = (state_q == ST_HOST_RD);
   assign cap_host_o  = (state_q == ST_HOST_WR) && h_write_i;
   assign cap_mem_o   = ((state_q == ST_MEM_RD) && !m_wait_i && m_rdv_i) ||
                        ((state_q == ST_MEM_RDV) && m_rdv_i);
   assign step_end    = ((state_q == ST_MEM_WR) && !m_wait_i) ||
                        ((state_q == ST_HOST_RD) && h_read_i);
   assign ctr_clear_o = (state_q == ST_IDLE) && start_i;
   assign ctr_adv_o   = step_end && !last_i;
   assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done_o      = (state_q == ST_DONE);

   // R9: never a write and a read toward memory together
   p_mem_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(m_write_o && m_read_o));

   // R8: completion is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R8: busy and done never overlap
   p_busy_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_o && done_o));

   // R3: host is stalled whenever no operation runs
   p_idle_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> h_wait_o);

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
   parameter int                 WORD_W     = 16,
   parameter int                 WORDS      = 4,
   parameter int                 ADDR_W     = 32,
   parameter int                 STEP_COUNT = 130326,
   parameter logic [ADDR_W-1:0]  BASE_ADDR  = 32'h3FF0_0000,
   parameter bit                 DATA_RESET = 1'b1
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          start_i,
   input  logic                          mode_i,
   output logic                          busy_o,
   output logic                          done_o,
   input  logic                          h_write_i,
   input  logic [WORD_W*WORDS-1:0]       h_writedata_i,
   input  logic                          h_read_i,
   output logic [WORD_W*WORDS-1:0]       h_readdata_o,
   output logic                          h_waitrequest_o,
   output logic [ADDR_W-1:0]             m_address_o,
   output logic                          m_write_o,
   output logic [WORD_W*WORDS-1:0]       m_writedata_o,
   output logic [(WORD_W*WORDS)/8-1:0]   m_byteenable_o,
   output logic                          m_read_o,
   input  logic                          m_waitrequest_i,
   input  logic [WORD_W*WORDS-1:0]       m_readdata_i,
   input  logic                          m_readdatavalid_i
);

   localparam int DATA_W      = WORD_W * WORDS;
   localparam int BE_W        = DATA_W / 8;
   localparam int BLOCK_BYTES = BE_W;

   if ((DATA_W % 8) != 0) begin : g_bad_data_w
      $error("blk_xfer_seq: block width must be whole bytes");
   end
   if (ADDR_W < 1 || ADDR_W > 62) begin : g_bad_addr_w
      $error("blk_xfer_seq: ADDR_W out of range");
   end

   logic              cap_host, cap_mem;
   logic              ctr_clear, ctr_adv, last_step, rd_win;
   logic [DATA_W-1:0] blk_q;

   xfer_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .mode_i      (mode_i),
      .h_write_i   (h_write_i),
      .h_read_i    (h_read_i),
      .m_wait_i    (m_waitrequest_i),
      .m_rdv_i     (m_readdatavalid_i),
      .last_i      (last_step),
      .h_wait_o    (h_waitrequest_o),
      .m_write_o   (m_write_o),
      .m_read_o    (m_read_o),
      .cap_host_o  (cap_host),
      .cap_mem_o   (cap_mem),
      .ctr_clear_o (ctr_clear),
      .ctr_adv_o   (ctr_adv),
      .rd_win_o    (rd_win),
      .busy_o      (busy_o),
      .done_o      (done_o)
   );

   xfer_step_ctr #(
      .ADDR_W      (ADDR_W),
      .STEP_COUNT  (STEP_COUNT),
      .BLOCK_BYTES (BLOCK_BYTES),
      .BASE_ADDR   (BASE_ADDR)
   ) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (ctr_clear),
      .adv_i   (ctr_adv),
      .addr_o  (m_address_o),
      .last_o  (last_step)
   );

   xfer_blk_reg #(
      .WORD_W     (WORD_W),
      .WORDS      (WORDS),
      .DATA_RESET (DATA_RESET)
   ) u_blk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_a_i  (cap_host),
      .data_a_i (h_writedata_i),
      .cap_b_i  (cap_mem),
      .data_b_i (m_readdata_i),
      .q_o      (blk_q)
   );

   assign h_readdata_o   = blk_q;
   assign m_writedata_o  = blk_q;
   assign m_byteenable_o = '1;

   // R4: a stalled memory write keeps its command, address and data
   p_wr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_write_o && m_waitrequest_i) |=>
         (m_write_o && $stable(m_address_o) && $stable(m_writedata_o)));

   // R6: a stalled memory read keeps its command and address
   p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_read_o && m_waitrequest_i) |=> (m_read_o && $stable(m_address_o)));

   // R7: host read data holds until the host read is taken
   p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_win && !h_read_i) |=> (rd_win && $stable(h_readdata_o)));

endmodule

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;

   localparam int          N    = 6;
   localparam logic [31:0] BASE = 32'h3FF0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, mode = 1'b0;
   logic        h_write = 1'b0, h_read = 1'b0;
   logic [63:0] h_wdata = '0;
   logic        m_wait = 1'b1, m_rdv = 1'b0;
   logic [63:0] m_rdata = '0;

   logic        busy_o, done_o, h_waitrequest_o, m_write_o, m_read_o;
   logic [63:0] h_readdata_o, m_writedata_o;
   logic [31:0] m_address_o;
   logic [7:0]  m_byteenable_o;

   always #10 clk = ~clk;

   blk_xfer_seq #(.STEP_COUNT(N), .BASE_ADDR(BASE)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
      .busy_o(busy_o), .done_o(done_o),
      .h_write_i(h_write), .h_writedata_i(h_wdata), .h_read_i(h_read),
      .h_readdata_o(h_readdata_o), .h_waitrequest_o(h_waitrequest_o),
      .m_address_o(m_address_o), .m_write_o(m_write_o), .m_writedata_o(m_writedata_o),
      .m_byteenable_o(m_byteenable_o), .m_read_o(m_read_o),
      .m_waitrequest_i(m_wait), .m_readdata_i(m_rdata), .m_readdatavalid_i(m_rdv)
   );

   int n_cmp = 0, n_bad = 0;

   // reference model state
   int          ph = 0, stp = 0;
   logic [63:0] mblk = '0;
   // stimulus state
   int          prof = 0, hs = 0, ms = 0, gap = 0, pend = 0;
   logic [31:0] pend_a = '0;
   logic        h_acc = 1'b0, host_on = 1'b0, cur_mode = 1'b0;
   logic        start_req = 1'b0, mode_req = 1'b0;
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] hdat(input int s);
      return {16'(s), 16'hC0DE, 16'(s * 3 + 1), 16'h5A00};
   endfunction

   function automatic logic [63:0] memfn(input logic [31:0] a);
      return {a, a ^ 32'h5A5A_A5A5};
   endfunction

   function automatic int gap_for(input int p, input int s);
      case (p)
         0:       return s % 4;
         1:       return (s * 2) % 3;
         3:       return 5;
         default: return 0;
      endcase
   endfunction

   task automatic tick();
      int lat;
      // compare outputs with the model state reached at the last edge
      chk("R8 busy_o", 64'(busy_o), 64'(ph >= 1 && ph <= 5));
      chk("R8 done_o", 64'(done_o), 64'(ph == 6));
      chk("R3 h_waitrequest_o", 64'(h_waitrequest_o), 64'(!(ph == 1 || ph == 5)));
      chk("R4 m_write_o", 64'(m_write_o), 64'(ph == 2));
      chk("R6 m_read_o", 64'(m_read_o), 64'(ph == 3));
      chk("R9 write and read together", 64'(m_write_o && m_read_o), 64'd0);
      if (ph == 2 || ph == 3) chk("R5 m_address_o", 64'(m_address_o), 64'(BASE + 32'(stp * 8)));
      if (ph == 2) begin
         chk("R4 m_writedata_o", m_writedata_o, mblk);
         chk("R4 m_byteenable_o", 64'(m_byteenable_o), 64'hFF);
      end
      if (ph == 5) chk("R7 h_readdata_o in window", h_readdata_o, mblk);

      // drive inputs for the next edge
      start     = start_req;
      mode      = mode_req;
      start_req = 1'b0;

      if (h_acc) begin
         h_write = 1'b0;
         h_read  = 1'b0;
         hs++;
         gap = gap_for(prof, hs);
      end else if (!h_write && !h_read && host_on) begin
         if (gap > 0) gap--;
         else if (cur_mode) h_read = 1'b1;
         else begin
            h_write = 1'b1;
            h_wdata = hdat(hs);
         end
      end

      lf    = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      m_rdv = 1'b0;
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            m_rdv   = 1'b1;
            m_rdata = memfn(pend_a);
         end
      end
      case (prof)
         0:       m_wait = lf[0] & lf[1];
         1:       m_wait = lf[0] & lf[2];
         3:       m_wait = lf[0] | lf[1];
         default: m_wait = 1'b0;
      endcase
      case (prof)
         1:       lat = int'(lf[4:3]) % 3;
         3:       lat = 2;
         default: lat = 0;
      endcase
      if (m_read_o && !m_wait) begin
         if (lat == 0) begin
            m_rdv   = 1'b1;
            m_rdata = memfn(m_address_o);
         end else begin
            pend   = lat;
            pend_a = m_address_o;
         end
      end
      if (m_write_o && !m_wait) begin
         chk("R5 accepted write address", 64'(m_address_o), 64'(BASE + 32'(ms * 8)));
         chk("R10 accepted write block", m_writedata_o, hdat(ms));
         ms++;
      end
      h_acc = (h_write || h_read) && !h_waitrequest_o;
      if (h_acc && h_read)
         chk("R7 accepted host read block", h_readdata_o, memfn(BASE + 32'(hs * 8)));

      // step the reference model with the inputs just driven
      case (ph)
         0: if (start) begin stp = 0; ph = mode ? 3 : 1; end
         1: if (h_write) begin mblk = h_wdata; ph = 2; end
         2: if (!m_wait) begin
               if (stp == N - 1) ph = 6;
               else begin stp++; ph = 1; end
            end
         3: if (!m_wait) begin
               if (m_rdv) begin mblk = m_rdata; ph = 5; end
               else ph = 4;
            end
         4: if (m_rdv) begin mblk = m_rdata; ph = 5; end
         5: if (h_read) begin
               if (stp == N - 1) ph = 6;
               else begin stp++; ph = 3; end
            end
         default: ph = 0;
      endcase
   endtask

   task automatic run_op(input int p);
      bit fin = 0;
      prof      = p;
      cur_mode  = (p == 1 || p == 3 || p == 4);
      hs = 0; ms = 0; pend = 0;
      gap       = gap_for(p, 0);
      h_acc     = 1'b0;
      host_on   = 1'b1;
      start_req = 1'b1;
      mode_req  = cur_mode;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         // R2: a start pulse of the other mode while busy must change nothing
         if (p == 0 && i == 12) begin start_req = 1'b1; mode_req = 1'b1; end
         tick();
         if (done_o) begin fin = 1; break; end
      end
      chk("R8 operation finished", 64'(fin), 64'd1);
      host_on = 1'b0;
      h_write = 1'b0;
      h_read  = 1'b0;
      h_acc   = 1'b0;
      chk("R8 host steps completed", 64'(hs), 64'(N));
      if (!cur_mode) chk("R8 memory writes completed", 64'(ms), 64'(N));
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         tick();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy_o in reset", 64'(busy_o), 64'd0);
      chk("R1 done_o in reset", 64'(done_o), 64'd0);
      chk("R1 h_waitrequest_o in reset", 64'(h_waitrequest_o), 64'd1);
      chk("R1 m_write_o in reset", 64'(m_write_o), 64'd0);
      chk("R1 m_read_o in reset", 64'(m_read_o), 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         tick();
      end
      for (int p = 0; p < 5; p++) run_op(p);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: R8 operation did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule